// File: doc/BRIEF.md
# Host Coefficient Write Port with Shadowed Control Word

This block is the host-facing write side of a multi-tap filter engine. A host drives an address, a data word and active-low select and write strobes. With control-select high the write goes to the 16-bit control word. With control-select low it goes to the coefficient RAM. Coefficients arrive either as whole 16-bit words or as a low byte followed by a high byte, and a strap input picks the mode. In byte mode the upper data nibbles carry a device tag, and a write is taken only when the two tag nibbles agree.

A control word written after reset does not act at once. It lands in a shadow register and a sequencer walks each control write through two hold cycles and a gap cycle. The shadow reaches the active control output only when the coefficient bank flips. The bank request comes from one of three places: an external pin, a bit of the control word, or an automatic alternation on every sample. The bank, and with it the active control word, changes only on a sample strobe. Coefficient writes beyond the span that the active length and decimation settings need are dropped.

Top module: `coef_host_port`

## Requirements
- R1: A write is accepted on a clock edge only when `host_cs_n` and `host_we_n` are both low. An accepted word-mode coefficient write shows `coef_we` high for one cycle after that edge.
- R2: In word mode (`word_mode`=1) a coefficient write presents `coef_addr` = `host_addr[6:0]` and `coef_data` = `host_data`. `host_addr[7]` is ignored.
- R3: Byte mode (`word_mode`=0) works as follows:
  - A coefficient write with `host_addr[0]`=0 stores `host_data[7:0]` as a low byte and produces no RAM write.
  - A following write with `host_addr[0]`=1 produces one RAM write at `host_addr[7:1]` with data {high byte, low byte}.
  - A high byte with no stored low byte is dropped.
  - A byte-mode control write replaces only the byte of the shadow chosen by `host_addr[0]`.
- R4: In byte mode a write is ignored unless `host_data[15:12]` equals `host_data[11:8]`. An ignored write leaves a stored low byte in place.
- R5: The control-write sequencer has four states:
  - IDLE: a control write is captured here and the sequencer moves to HOLD1.
  - HOLD1: moves to HOLD2 when `host_cs_n` is low, otherwise to GAP.
  - HOLD2: always moves to GAP, and commits the captured word to the shadow only if `host_cs_n` is still low.
  - GAP: always returns to IDLE.
  - Any write offered outside IDLE is ignored.
- R6: After reset `ctl_active` = 0x8C80, the shadow holds 0x8C80, `bank_upper` = 0 and `coef_we` = 0.
- R7: A committed control word does not appear on `ctl_active` until a sample strobe flips the bank. At that edge `ctl_active` takes the shadow value. `ctl_active` never changes on an edge where the bank does not change.
- R8: With shadow bit 5 = 0, the requested bank is chosen as follows:
  - Shadow bit 7 = 1: the requested bank is shadow bit 6.
  - Shadow bit 7 = 0: the requested bank is `swap_pin`.
  - In both cases 0 means lower and 1 means upper.
- R9: `bank_upper` changes only on a clock edge where `sample_stb` is high.
- R10: With shadow bit 5 = 1 the bank alternates on every sample strobe and ignores `swap_pin` and bit 6. The first strobe after a `run_go` pulse, or a strobe in the same cycle as `run_go`, selects the lower bank.
- R11: A coefficient write is dropped when its address is at or above 2^k, where k = min(7, 5 + `ctl_active[14:13]` + `ctl_active[12]`). This limit is 32 at the reset word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 8 | Host address |
| host_ctl_sel | input | 1 | 1 selects the control word, 0 the coefficient RAM |
| host_data | input | 16 | Host write data |
| host_cs_n | input | 1 | Active-low chip select |
| host_we_n | input | 1 | Active-low write enable |
| word_mode | input | 1 | Strap: 1 word writes, 0 byte writes |
| swap_pin | input | 1 | External bank request |
| sample_stb | input | 1 | One-cycle sample strobe |
| run_go | input | 1 | Start pulse; restarts alternation at the lower bank |
| ctl_active | output | 16 | Control word in force |
| bank_upper | output | 1 | 1 when the upper coefficient bank is in use |
| coef_we | output | 1 | Coefficient RAM write strobe |
| coef_addr | output | 7 | Coefficient RAM address |
| coef_data | output | 16 | Coefficient RAM data |

## Verification
A table of word-mode writes mixes in-range addresses, an address with bit 7 set, and addresses just at and far beyond the reset-time limit. This separates address truncation from range filtering. Byte sequences pair matching and mismatching tag nibbles with low-then-high, high-only and tag-rejected orders, which tells gating apart from byte-order tracking. Control writes are made with full holds, a short hold and a probe in the gap cycle, and their effect is then read through the bank flip on `sample_stb`. Every bank source is driven in turn: the register bit, the pin with and without a strobe, and alternation with `swap_pin` held opposite to the expected bank.

// File: rtl/chp_pkg.sv
package chp_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_HOLD1,
        SEQ_HOLD2,
        SEQ_GAP
    } seq_state_t;

    localparam int BIT_ALT      = 5;
    localparam int BIT_REG_BANK = 6;
    localparam int BIT_SRC_REG  = 7;
    localparam int BIT_DECIM    = 12;
    localparam int BIT_LEN_LO   = 13;
    localparam int BIT_LEN_HI   = 14;
endpackage

// File: rtl/chp_ctl_seq.sv
module chp_ctl_seq
    import chp_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_hit,
    input  logic          ctl_sel,
    input  logic          cs_n,
    input  logic          word_mode,
    input  logic          addr0,
    input  logic [DW-1:0] data,
    output seq_state_t    state,
    output logic          coef_ok,
    output logic          commit,
    output logic [DW-1:0] commit_data,
    output logic [1:0]    commit_mask
);
    localparam int HALF = DW / 2;

    seq_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            SEQ_IDLE:  if (wr_hit && ctl_sel) nxt = SEQ_HOLD1;
            SEQ_HOLD1: nxt = cs_n ? SEQ_GAP : SEQ_HOLD2;
            SEQ_HOLD2: nxt = SEQ_GAP;
            SEQ_GAP:   nxt = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEQ_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_data <= '0;
            commit_mask <= '0;
        end else if (state == SEQ_IDLE && wr_hit && ctl_sel) begin
            commit_data <= word_mode ? data : {data[HALF-1:0], data[HALF-1:0]};
            commit_mask <= word_mode ? 2'b11 : (addr0 ? 2'b10 : 2'b01);
        end
    end

    always_comb begin
        coef_ok = (state == SEQ_IDLE);
        commit  = (state == SEQ_HOLD2) && !cs_n;
    end
endmodule

// File: rtl/chp_coef_wr.sv
module chp_coef_wr #(
    parameter int AW = 8,
    parameter int DW = 16,
    parameter int LW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          word_mode,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    input  logic [LW-1:0] lim_log,
    output logic          coef_we,
    output logic [AW-2:0] coef_addr,
    output logic [DW-1:0] coef_data
);
    localparam int CAW  = AW - 1;
    localparam int HALF = DW / 2;

    logic [CAW-1:0]  tgt;
    logic            in_range;
    logic            complete;
    logic [HALF-1:0] low_hold;
    logic            low_valid;

    always_comb begin
        tgt      = word_mode ? addr[CAW-1:0] : addr[AW-1:1];
        in_range = ((tgt >> lim_log) == '0);
        complete = wr_en && (word_mode || (addr[0] && low_valid));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_hold  <= '0;
            low_valid <= 1'b0;
            coef_we   <= 1'b0;
            coef_addr <= '0;
            coef_data <= '0;
        end else begin
            if (wr_en && !word_mode) begin
                if (!addr[0]) begin
                    low_hold  <= data[HALF-1:0];
                    low_valid <= 1'b1;
                end else begin
                    low_valid <= 1'b0;
                end
            end
            coef_we <= complete && in_range;
            if (complete) begin
                coef_addr <= tgt;
                coef_data <= word_mode ? data : {data[HALF-1:0], low_hold};
            end
        end
    end
endmodule

// File: rtl/chp_bank_ctl.sv
module chp_bank_ctl
    import chp_pkg::*;
#(
    parameter int          DW         = 16,
    parameter logic [15:0] RESET_WORD = 16'h8C80
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit,
    input  logic [DW-1:0] commit_data,
    input  logic [1:0]    commit_mask,
    input  logic          swap_pin,
    input  logic          sample_stb,
    input  logic          run_go,
    output logic [DW-1:0] ctl_active,
    output logic          bank_upper
);
    localparam int HALF = DW / 2;

    logic [DW-1:0] shadow;
    logic          alt_next;
    logic          alt_req;
    logic          req;

    always_comb begin
        alt_req = run_go ? 1'b0 : alt_next;
        if (shadow[BIT_ALT])          req = alt_req;
        else if (shadow[BIT_SRC_REG]) req = shadow[BIT_REG_BANK];
        else                          req = swap_pin;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow     <= RESET_WORD[DW-1:0];
            ctl_active <= RESET_WORD[DW-1:0];
            bank_upper <= 1'b0;
            alt_next   <= 1'b0;
        end else begin
            if (commit) begin
                if (commit_mask[0]) shadow[HALF-1:0]  <= commit_data[HALF-1:0];
                if (commit_mask[1]) shadow[DW-1:HALF] <= commit_data[DW-1:HALF];
            end
            if (sample_stb) begin
                if (shadow[BIT_ALT]) alt_next <= ~alt_req;
                if (req != bank_upper) begin
                    bank_upper <= req;
                    ctl_active <= shadow;
                end
            end else if (run_go) begin
                alt_next <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/coef_host_port.sv
module coef_host_port
    import chp_pkg::*;
#(
    parameter int          ADDR_W     = 8,
    parameter int          DATA_W     = 16,
    parameter int          MIN_LOG    = 5,
    parameter logic [15:0] RESET_WORD = 16'h8C80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_ctl_sel,
    input  logic [DATA_W-1:0] host_data,
    input  logic              host_cs_n,
    input  logic              host_we_n,
    input  logic              word_mode,
    input  logic              swap_pin,
    input  logic              sample_stb,
    input  logic              run_go,
    output logic [DATA_W-1:0] ctl_active,
    output logic              bank_upper,
    output logic              coef_we,
    output logic [ADDR_W-2:0] coef_addr,
    output logic [DATA_W-1:0] coef_data
);
    localparam int CAW = ADDR_W - 1;
    localparam int LW  = $clog2(CAW + 1);
    localparam int SW  = LW + 1;

    seq_state_t        seq_state;
    logic              tag_match;
    logic              wr_hit;
    logic              coef_ok;
    logic              commit;
    logic [DATA_W-1:0] commit_data;
    logic [1:0]        commit_mask;
    logic [SW-1:0]     lim_sum;
    logic [LW-1:0]     lim_log;

    always_comb begin
        tag_match = (host_data[15:12] == host_data[11:8]);
        wr_hit    = !host_cs_n && !host_we_n && (word_mode || tag_match);
        lim_sum   = SW'(MIN_LOG) + SW'(ctl_active[BIT_LEN_HI:BIT_LEN_LO])
                  + SW'(ctl_active[BIT_DECIM]);
        lim_log   = (lim_sum > SW'(CAW)) ? LW'(CAW) : lim_sum[LW-1:0];
    end

    chp_ctl_seq #(.DW(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .ctl_sel(host_ctl_sel),
        .cs_n(host_cs_n), .word_mode(word_mode), .addr0(host_addr[0]),
        .data(host_data), .state(seq_state), .coef_ok(coef_ok),
        .commit(commit), .commit_data(commit_data), .commit_mask(commit_mask)
    );

    chp_coef_wr #(.AW(ADDR_W), .DW(DATA_W), .LW(LW)) u_coef (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_hit && !host_ctl_sel && coef_ok),
        .word_mode(word_mode), .addr(host_addr), .data(host_data),
        .lim_log(lim_log), .coef_we(coef_we), .coef_addr(coef_addr),
        .coef_data(coef_data)
    );

    chp_bank_ctl #(.DW(DATA_W), .RESET_WORD(RESET_WORD)) u_bank (
        .clk(clk), .rst_n(rst_n), .commit(commit), .commit_data(commit_data),
        .commit_mask(commit_mask), .swap_pin(swap_pin), .sample_stb(sample_stb),
        .run_go(run_go), .ctl_active(ctl_active), .bank_upper(bank_upper)
    );
endmodule

// File: rtl/chp_checker.sv
module chp_checker
    import chp_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        host_cs_n,
    input logic        host_we_n,
    input logic        sample_stb,
    input logic        bank_upper,
    input logic [15:0] ctl_active,
    input logic        coef_we,
    input seq_state_t  seq_state
);
    a_r1_write_needs_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cs_n || host_we_n) |=> !coef_we);

    a_r5_busy_blocks_coef: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state != SEQ_IDLE) |=> !coef_we);

    a_r9_bank_only_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_stb |=> $stable(bank_upper));

    a_r7_active_tracks_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_upper == $past(bank_upper)) |-> (ctl_active == $past(ctl_active)));
endmodule

bind coef_host_port chp_checker u_chk (
    .clk(clk), .rst_n(rst_n), .host_cs_n(host_cs_n), .host_we_n(host_we_n),
    .sample_stb(sample_stb), .bank_upper(bank_upper), .ctl_active(ctl_active),
    .coef_we(coef_we), .seq_state(seq_state)
);

// File: tb/tb_coef_host_port.sv
module tb_coef_host_port;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    // {addr, data, expect_we, expect_addr}
    localparam logic [31:0] VEC [0:NVEC-1] = '{
        {8'h05, 16'h1234, 1'b1, 7'h05},
        {8'h85, 16'hBEEF, 1'b1, 7'h05},
        {8'h1F, 16'h7FFF, 1'b1, 7'h1F},
        {8'h20, 16'h0001, 1'b0, 7'h00},
        {8'h7F, 16'h8000, 1'b0, 7'h00},
        {8'h00, 16'hFFFF, 1'b1, 7'h00}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  host_addr;
    logic        host_ctl_sel;
    logic [15:0] host_data;
    logic        host_cs_n, host_we_n, word_mode, swap_pin, sample_stb, run_go;
    logic [15:0] ctl_active;
    logic        bank_upper, coef_we;
    logic [6:0]  coef_addr;
    logic [15:0] coef_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    coef_host_port dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_ctl_sel(host_ctl_sel),
        .host_data(host_data), .host_cs_n(host_cs_n), .host_we_n(host_we_n),
        .word_mode(word_mode), .swap_pin(swap_pin), .sample_stb(sample_stb),
        .run_go(run_go), .ctl_active(ctl_active), .bank_upper(bank_upper),
        .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic coef_wr(input logic [7:0] a, input logic [15:0] d);
        host_ctl_sel = 1'b0; host_addr = a; host_data = d;
        host_cs_n = 1'b0; host_we_n = 1'b0;
        tick();
        host_cs_n = 1'b1; host_we_n = 1'b1;
    endtask

    task automatic ctl_wr(input logic [7:0] a, input logic [15:0] d, input int holds);
        host_ctl_sel = 1'b1; host_addr = a; host_data = d;
        host_cs_n = 1'b0; host_we_n = 1'b0;
        tick();
        host_we_n = 1'b1;
        for (int i = 0; i < holds; i++) tick();
        host_cs_n = 1'b1; host_ctl_sel = 1'b0;
    endtask

    task automatic strobe();
        sample_stb = 1'b1;
        tick();
        sample_stb = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; host_addr = '0; host_ctl_sel = 1'b0; host_data = '0;
        host_cs_n = 1'b1; host_we_n = 1'b1; word_mode = 1'b1; swap_pin = 1'b0;
        sample_stb = 1'b0; run_go = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        tick();
        chk("R6 active reset", ctl_active, 16'h8C80);
        chk("R6 bank reset", {15'd0, bank_upper}, 16'd0);
        chk("R6 we reset", {15'd0, coef_we}, 16'd0);

        // R2/R11 vector walk in word mode
        for (int v = 0; v < NVEC; v++) begin
            coef_wr(VEC[v][31:24], VEC[v][23:8]);
            chk("R2 R11 vec we", {15'd0, coef_we}, {15'd0, VEC[v][7]});
            if (VEC[v][7]) begin
                chk("R2 vec addr", {9'd0, coef_addr}, {9'd0, VEC[v][6:0]});
                chk("R2 vec data", coef_data, VEC[v][23:8]);
            end
        end

        // R1: strobes not both low
        host_addr = 8'h03; host_data = 16'h1111; host_cs_n = 1'b0; host_we_n = 1'b1;
        tick();
        chk("R1 we_n high", {15'd0, coef_we}, 16'd0);
        host_cs_n = 1'b1; host_we_n = 1'b0;
        tick();
        chk("R1 cs_n high", {15'd0, coef_we}, 16'd0);
        host_we_n = 1'b1;

        // R3/R4 byte mode
        word_mode = 1'b0;
        coef_wr(8'h0A, 16'h33AB);
        chk("R3 low byte no write", {15'd0, coef_we}, 16'd0);
        coef_wr(8'h0B, 16'h33CD);
        chk("R3 pair we", {15'd0, coef_we}, 16'd1);
        chk("R3 pair addr", {9'd0, coef_addr}, 16'd5);
        chk("R3 pair data", coef_data, 16'hCDAB);
        coef_wr(8'h0C, 16'h34AB);
        coef_wr(8'h0D, 16'h4456);
        chk("R4 tag-rejected low leaves no pair", {15'd0, coef_we}, 16'd0);
        coef_wr(8'h0E, 16'h5511);
        coef_wr(8'h0F, 16'h5622);
        chk("R4 tag-rejected high", {15'd0, coef_we}, 16'd0);
        coef_wr(8'h0F, 16'h5522);
        chk("R4 low byte kept we", {15'd0, coef_we}, 16'd1);
        chk("R4 low byte kept data", coef_data, 16'h2211);
        coef_wr(8'h0F, 16'h5533);
        chk("R3 high without low", {15'd0, coef_we}, 16'd0);
        word_mode = 1'b1;

        // R5/R7/R8 control write, gap probe, register bank source
        ctl_wr(8'h00, 16'h8CC0, 2);
        coef_wr(8'h02, 16'h0202);
        chk("R5 write in gap ignored", {15'd0, coef_we}, 16'd0);
        coef_wr(8'h02, 16'h0202);
        chk("R5 write after gap", {15'd0, coef_we}, 16'd1);
        chk("R7 shadow not active", ctl_active, 16'h8C80);
        chk("R9 no strobe no bank", {15'd0, bank_upper}, 16'd0);
        strobe();
        chk("R8 register bank upper", {15'd0, bank_upper}, 16'd1);
        chk("R7 active after flip", ctl_active, 16'h8CC0);

        // R5 short hold: not committed
        ctl_wr(8'h00, 16'h8C40, 1);
        repeat (2) tick();
        strobe();
        chk("R5 short hold discarded bank", {15'd0, bank_upper}, 16'd1);
        chk("R5 short hold discarded active", ctl_active, 16'h8CC0);

        // R8/R9 pin source
        ctl_wr(8'h00, 16'h8C00, 2);
        repeat (2) tick();
        chk("R9 bank held before strobe", {15'd0, bank_upper}, 16'd1);
        strobe();
        chk("R8 pin low lower bank", {15'd0, bank_upper}, 16'd0);
        chk("R7 active pin mode", ctl_active, 16'h8C00);
        swap_pin = 1'b1;
        repeat (3) tick();
        chk("R9 pin without strobe", {15'd0, bank_upper}, 16'd0);
        strobe();
        chk("R8 pin high upper bank", {15'd0, bank_upper}, 16'd1);

        // R10 alternation, pin held high
        ctl_wr(8'h00, 16'h8C20, 2);
        repeat (2) tick();
        run_go = 1'b1; tick(); run_go = 1'b0;
        chk("R10 run_go alone no change", {15'd0, bank_upper}, 16'd1);
        strobe();
        chk("R10 first lower", {15'd0, bank_upper}, 16'd0);
        chk("R10 active", ctl_active, 16'h8C20);
        strobe();
        chk("R10 second upper", {15'd0, bank_upper}, 16'd1);
        strobe();
        chk("R10 third lower", {15'd0, bank_upper}, 16'd0);

        // R11 limit follows active length
        ctl_wr(8'h00, 16'hEC20, 2);
        repeat (2) tick();
        coef_wr(8'h50, 16'h5050);
        chk("R11 beyond 32 dropped", {15'd0, coef_we}, 16'd0);
        strobe();
        chk("R11 active long", ctl_active, 16'hEC20);
        coef_wr(8'h50, 16'h5050);
        chk("R11 long accepted", {15'd0, coef_we}, 16'd1);
        chk("R11 long addr", {9'd0, coef_addr}, 16'h0050);

        // R3 byte-mode control write, low byte only
        word_mode = 1'b0;
        ctl_wr(8'h00, 16'h22E0, 2);
        repeat (2) tick();
        strobe();
        chk("R3 byte control merge", ctl_active, 16'hECE0);
        chk("R10 alternation continues", {15'd0, bank_upper}, 16'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule